// File: doc/BRIEF.md
# Coin Vending Controller with Change Return

This block is the sequencing core of a single-product drink dispenser priced at 30 cents. A coin acceptor upstream delivers one-cycle pulses for a 25-cent, 10-cent or 5-cent coin. The controller adds them up in 5-cent steps. When the total reaches 30 cents or more, it commands one can. It then pays back any excess as a run of dime and nickel commands, one per clock cycle.

The controller is a Moore machine. Each state represents either the credit collected so far or a step of the payout. All three commands are flip-flop outputs, and each flip-flop is loaded from a decode of the next state. A command therefore lines up exactly with the state it belongs to. Because it comes straight from a flop, it cannot carry decode hazards from state bits that switch at slightly different times. While a can or change is being delivered, coin pulses are ignored.

Top module: `vend_ctrl`

## Requirements
- R1: From an accepting state (credit 0 to 25 cents), a pulse on `coin_n`, `coin_d` or `coin_q` adds 5, 10 or 25 cents at that clock edge. A cycle with no coin pulse leaves the credit unchanged.
- R2: When several coin inputs are high in the same cycle, only one coin is credited, chosen in the order quarter, then dime, then nickel.
- R3: At the clock edge where the credit reaches 30 cents or more, `vend_can` goes high for exactly one cycle. It goes high right after that edge, and all commands change only at clock edges or on reset.
- R4: Change follows the can in the cycles that come right after it:
  - 35 cents gives one nickel.
  - 40 cents gives one dime.
  - 45 cents gives a dime, then a nickel.
  - 50 cents gives two dimes.
- R5: At most one of `vend_can`, `vend_dime` and `vend_nickel` is high in any cycle.
- R6: Coin pulses have no effect while the can or change is being delivered. The cycle after the last command (or after the can, when there is no change) has no command, and the credit after it is zero.
- R7: A low on `rst_n` clears all three commands and the credit at once, with no clock edge needed. This holds even in the middle of a payout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| coin_q | input | 1 | One-cycle pulse: 25-cent coin accepted |
| coin_d | input | 1 | One-cycle pulse: 10-cent coin accepted |
| coin_n | input | 1 | One-cycle pulse: 5-cent coin accepted |
| vend_can | output | 1 | One-cycle command: release a can |
| vend_dime | output | 1 | One-cycle command: pay out a dime |
| vend_nickel | output | 1 | One-cycle command: pay out a nickel |

## Verification
The controller has no parameters, so the bench builds its only configuration. It drives every sequence of four coin-input patterns, using all eight combinations of the three coin pulses in each cycle, including illegal multi-coin cycles. Each sequence is followed by idle cycles. Because the state carries over from one sequence to the next, every credit level, every payout chain, and coins arriving during delivery are all reached. An arithmetic credit-and-change model checks every cycle. A separate test pulls reset in the middle of a payout and confirms that the credit restarts from zero.

// File: rtl/vend_ctrl.sv
`timescale 1ns/1ps
module vend_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic coin_q,
  input  logic coin_d,
  input  logic coin_n,
  output logic vend_can,
  output logic vend_dime,
  output logic vend_nickel
);
  // codes 0..10 hold credit/5; 11..14 are payout steps
  localparam logic [3:0] IDLE  = 4'd0;
  localparam logic [3:0] C25   = 4'd5;
  localparam logic [3:0] C30   = 4'd6;
  localparam logic [3:0] C35   = 4'd7;
  localparam logic [3:0] C40   = 4'd8;
  localparam logic [3:0] C45   = 4'd9;
  localparam logic [3:0] C50   = 4'd10;
  localparam logic [3:0] RET20 = 4'd11;
  localparam logic [3:0] RET15 = 4'd12;
  localparam logic [3:0] RET10 = 4'd13;
  localparam logic [3:0] RET5  = 4'd14;

  logic [3:0] st, nx, step;

  assign step = coin_q ? 4'd5 : coin_d ? 4'd2 : coin_n ? 4'd1 : 4'd0;

  always_comb begin
    if (st <= C25) nx = st + step;
    else begin
      case (st)
        C30:     nx = IDLE;
        C35:     nx = RET5;
        C40:     nx = RET10;
        C45:     nx = RET15;
        C50:     nx = RET20;
        RET20:   nx = RET10;
        RET15:   nx = RET5;
        RET10:   nx = IDLE;
        RET5:    nx = IDLE;
        default: nx = IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= IDLE;
      vend_can    <= 1'b0;
      vend_dime   <= 1'b0;
      vend_nickel <= 1'b0;
    end else begin
      st          <= nx;
      vend_can    <= (nx >= C30) && (nx <= C50);
      vend_dime   <= (nx == RET20) || (nx == RET15) || (nx == RET10);
      vend_nickel <= (nx == RET5);
    end
  end
endmodule

// File: rtl/vend_ctrl_chk.sv
`timescale 1ns/1ps
module vend_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic coin_q,
  input logic coin_d,
  input logic coin_n,
  input logic vend_can,
  input logic vend_dime,
  input logic vend_nickel
);
  // R5
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vend_can, vend_dime, vend_nickel}));

  // R3
  can_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vend_can |=> !vend_can);

  // R3
  can_after_coin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vend_can) |-> $past(coin_q || coin_d || coin_n));

  // R4
  nickel_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vend_nickel |=> !(vend_can || vend_dime || vend_nickel));

  // R6
  no_can_after_dime_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vend_dime |=> !vend_can);
endmodule

bind vend_ctrl vend_ctrl_chk chk (
  .clk(clk), .rst_n(rst_n), .coin_q(coin_q), .coin_d(coin_d), .coin_n(coin_n),
  .vend_can(vend_can), .vend_dime(vend_dime), .vend_nickel(vend_nickel)
);

// File: tb/tb_vend_ctrl.sv
`timescale 1ns/1ps
module tb_vend_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coin_q = 1'b0, coin_d = 1'b0, coin_n = 1'b0;
  logic vend_can, vend_dime, vend_nickel;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int credit = 0;
  int chg = 0;
  bit busy = 1'b0;

  always #4 clk = ~clk;

  vend_ctrl dut (
    .clk(clk), .rst_n(rst_n), .coin_q(coin_q), .coin_d(coin_d), .coin_n(coin_n),
    .vend_can(vend_can), .vend_dime(vend_dime), .vend_nickel(vend_nickel)
  );

  task automatic check3(input string tag, input logic [2:0] exp);
    logic [2:0] act;
    act = {vend_can, vend_dime, vend_nickel};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {can,dime,nickel} actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle of coins (bit2 quarter, bit1 dime, bit0 nickel), check after the edge
  task automatic step(input logic [2:0] c);
    logic [2:0] exp;
    string tag;
    int val;
    exp = 3'b000;
    tag = "R1";
    if (busy) begin
      if (c != 3'b000) tag = "R6";
      if (chg == 0) begin
        busy = 1'b0; credit = 0;
      end else if (chg >= 10) begin
        exp = 3'b010; chg -= 10; tag = "R4";
      end else begin
        exp = 3'b001; chg -= 5; tag = "R4";
      end
    end else begin
      val = c[2] ? 25 : c[1] ? 10 : c[0] ? 5 : 0;
      if ($countones(c) > 1) tag = "R2";
      credit += val;
      if (credit >= 30) begin
        exp = 3'b100; chg = credit - 30; busy = 1'b1; credit = 0; tag = "R3";
      end
    end
    {coin_q, coin_d, coin_n} = c;
    @(negedge clk);
    check3(tag, exp);
    checks++;
    if ($countones({vend_can, vend_dime, vend_nickel}) > 1) begin
      fails++;
      $display("FAIL R5: actual %b expected at most one high", {vend_can, vend_dime, vend_nickel});
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #10;
    check3("R7", 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check3("R7", 3'b000);
    for (int s = 0; s < 4096; s++) begin
      for (int k = 0; k < 4; k++) step(3'((s >> (3 * k)) & 7));
      for (int k = 0; k < 5; k++) step(3'b000);
    end
    // R7: reset in the middle of a payout clears commands and credit
    step(3'b100);
    {coin_q, coin_d, coin_n} = 3'b011;
    @(posedge clk);
    #2;
    check3("R7", 3'b100);
    rst_n = 1'b0;
    {coin_q, coin_d, coin_n} = 3'b000;
    #1;
    check3("R7", 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    busy = 1'b0; credit = 0; chg = 0;
    step(3'b001);
    step(3'b100);
    for (int k = 0; k < 4; k++) step(3'b000);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule